// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the processor-facing side of a floppy disk controller. A host reaches five registers over an 8-bit data path qualified by an active-low select, a read/write level and a two-bit register address. The address map is asymmetric: location 0 returns status on a read and accepts a command on a write. The other three locations hold the track, the sector and the data byte in both directions. The data path is split into an input, an output and a pad enable, so the chip's I/O ring can build the three-state pin.

Toward the disk, the block swaps whole bytes with a serial shift register. In a disk read, a single-cycle `byteReady` pulse hands in an assembled byte. In a disk write, a single-cycle `byteNeeded` pulse takes the next byte out. A data-request flag paces the host through these transfers. The block flags a byte lost to overrun or underrun, and it sends all zeroes when the host misses a write slot. A command sequencer outside the block sees each new command as a one-cycle start pulse with its code. It reports back through a completion pulse and a force-interrupt pulse, and these drive the busy flag and the interrupt request.

Top module: `fdc_host_regs`

## Requirements
- R1: `hostDataOe` is 1 exactly when `csN`=0 and `rdWrN`=1, and 0 otherwise.
- R2: The address decode is fixed. A read at 0 returns status and a write at 0 loads the command. Address 1 selects track, 2 selects sector and 3 selects the data register, for both reads and writes.
- R3: A host access takes effect only in the first clock cycle of a select period, where the previous cycle had `csN`=1. A write captures the data present in that cycle. Later cycles of the same select period change no state.
- R4: The status byte carries busy in bit 0, DRQ in bit 1 and lost data in bit 2. All other bits are 0.
- R5: A `byteReady` pulse loads `diskByteIn` into the data register and sets DRQ. A host read of the data register clears DRQ.
- R6: A `byteReady` pulse while DRQ is already set also sets lost data, and the new byte replaces the old one.
- R7: During a `byteNeeded` pulse with DRQ clear, `diskByteOut` equals the data register. Each `byteNeeded` pulse sets DRQ, and a host write of the data register clears it.
- R8: During a `byteNeeded` pulse with DRQ set, `diskByteOut` is 8'h00 and lost data becomes set.
- R9: A command write stores the code and sets busy. It clears INTRQ and lost data. In the next cycle `cmdStart` is 1 for one cycle, with `cmdCode` equal to the written code.
- R10: `cmdDone` clears busy and sets INTRQ. `forceIrq` sets INTRQ and leaves busy unchanged. A command write in the same cycle overrides both.
- R11: A host status read clears INTRQ, unless `cmdDone` or `forceIrq` is present in the same cycle, in which case INTRQ stays 1.
- R12: After reset, DRQ, INTRQ, lost data and busy are 0, and the track, sector, data and command registers read 0.
- R13: When `byteReady` and a host data write fall in the same cycle, the disk byte is kept and DRQ is 1. When `byteNeeded` and a host data write fall in the same cycle, the outgoing byte follows the earlier state, the host byte is kept and DRQ is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low master reset |
| csN | input | 1 | Active-low register select |
| rdWrN | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Register address |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | Pad drive enable for the host data path |
| byteReady | input | 1 | Disk read byte strobe |
| diskByteIn | input | 8 | Byte from the read shift register |
| byteNeeded | input | 1 | Disk write byte strobe |
| diskByteOut | output | 8 | Byte to the write shift register |
| cmdDone | input | 1 | Command completion pulse |
| forceIrq | input | 1 | Force-interrupt condition pulse |
| cmdStart | output | 1 | One-cycle pulse after a command write |
| cmdCode | output | 8 | Command register contents |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |

## Verification
A stuck or wrongly ordered DRQ shows on the `drq` pin and in status bit 1 one cycle after the strobe that should have changed it. Within the next disk strobe it also spoils the lost-data flag or turns a good outgoing byte into zeroes. A missing select-edge qualification corrupts a register during a held select, and the next read of that register shows it. Errors in the interrupt logic or the priority of its set and clear events show on `intrq` in the cycle after the event.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CMDSTAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_TRACK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_SECTOR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_DATA    = 2'd3;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic wrCmd;
    logic wrTrack;
    logic wrSector;
    logic wrData;
    logic rdStatus;
    logic rdData;
  } hostStrobes_t;
endpackage

// File: rtl/fdc_host_ctrl.sv
module fdc_host_ctrl
  import fdc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteReady,
  input  logic              byteNeeded,
  input  logic              cmdDone,
  input  logic              forceIrq,
  output hostStrobes_t      strb,
  output logic              busOe,
  output logic              drq,
  output logic              lostData,
  output logic              busy,
  output logic              intrq,
  output logic              cmdStart
);
  logic csHeld;
  logic accStart;

  assign accStart = !csN && !csHeld;
  assign busOe    = !csN && rdWrN;

  always_comb begin
    strb          = '0;
    strb.wrCmd    = accStart && !rdWrN && (addr == ADR_CMDSTAT);
    strb.wrTrack  = accStart && !rdWrN && (addr == ADR_TRACK);
    strb.wrSector = accStart && !rdWrN && (addr == ADR_SECTOR);
    strb.wrData   = accStart && !rdWrN && (addr == ADR_DATA);
    strb.rdStatus = accStart &&  rdWrN && (addr == ADR_CMDSTAT);
    strb.rdData   = accStart &&  rdWrN && (addr == ADR_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHeld   <= 1'b0;
      drq      <= 1'b0;
      lostData <= 1'b0;
      busy     <= 1'b0;
      intrq    <= 1'b0;
      cmdStart <= 1'b0;
    end else begin
      csHeld   <= !csN;
      cmdStart <= strb.wrCmd;
      // data request: disk events take precedence over host accesses
      if (byteReady)
        drq <= 1'b1;
      else if (byteNeeded)
        drq <= !strb.wrData;
      else if (strb.wrData || strb.rdData)
        drq <= 1'b0;
      // lost data: overrun or underrun, cleared by a new command
      if (strb.wrCmd)
        lostData <= 1'b0;
      else if ((byteReady || byteNeeded) && drq)
        lostData <= 1'b1;
      if (strb.wrCmd)
        busy <= 1'b1;
      else if (cmdDone)
        busy <= 1'b0;
      if (strb.wrCmd)
        intrq <= 1'b0;
      else if (cmdDone || forceIrq)
        intrq <= 1'b1;
      else if (strb.rdStatus)
        intrq <= 1'b0;
    end
  end

  AST_DRQ_ON_BYTE_IN: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |=> drq); // R5
  AST_LOST_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    byteReady && drq && !strb.wrCmd |=> lostData); // R6
  AST_LOST_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    byteNeeded && drq && !strb.wrCmd |=> lostData); // R8
  AST_CMD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |=> busy && !intrq && !lostData && cmdStart); // R9
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone && !strb.wrCmd |=> intrq && !busy); // R10
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus && !cmdDone && !forceIrq |=> !intrq); // R11
  AST_HELD_SELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !csN && $past(!csN) |-> strb == '0); // R3
endmodule

// File: rtl/fdc_host_dpath.sv
module fdc_host_dpath
  import fdc_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobes_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] diskByteIn,
  input  logic              byteReady,
  input  logic              byteNeeded,
  input  logic              drq,
  input  logic              lostData,
  input  logic              busy,
  output logic [DATA_W-1:0] hostDataOut,
  output logic [DATA_W-1:0] diskByteOut,
  output logic [DATA_W-1:0] cmdCode
);
  localparam int STAT_PAD = DATA_W - 3;

  logic [DATA_W-1:0] cmdReg, trackReg, sectorReg, dataReg;
  logic [DATA_W-1:0] statusByte;

  assign statusByte  = {{STAT_PAD{1'b0}}, lostData, drq, busy};
  assign cmdCode     = cmdReg;
  // underrun substitutes an all-zero byte
  assign diskByteOut = drq ? '0 : dataReg;

  always_comb begin
    unique case (addr)
      ADR_CMDSTAT: hostDataOut = statusByte;
      ADR_TRACK:   hostDataOut = trackReg;
      ADR_SECTOR:  hostDataOut = sectorReg;
      default:     hostDataOut = dataReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      trackReg  <= '0;
      sectorReg <= '0;
      dataReg   <= '0;
    end else begin
      if (strb.wrCmd)    cmdReg    <= hostDataIn;
      if (strb.wrTrack)  trackReg  <= hostDataIn;
      if (strb.wrSector) sectorReg <= hostDataIn;
      if (byteReady)
        dataReg <= diskByteIn;
      else if (strb.wrData)
        dataReg <= hostDataIn;
    end
  end

  AST_BYTE_IN_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |=> dataReg == $past(diskByteIn)); // R5
  AST_HOST_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData && !byteReady |=> dataReg == $past(hostDataIn)); // R13
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdWrN,
  input  logic [1:0] addr,
  input  logic [7:0] hostDataIn,
  output logic [7:0] hostDataOut,
  output logic       hostDataOe,
  input  logic       byteReady,
  input  logic [7:0] diskByteIn,
  input  logic       byteNeeded,
  output logic [7:0] diskByteOut,
  input  logic       cmdDone,
  input  logic       forceIrq,
  output logic       cmdStart,
  output logic [7:0] cmdCode,
  output logic       drq,
  output logic       intrq
);
  hostStrobes_t strb;
  logic lostData, busy;

  fdc_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addr(addr),
    .byteReady(byteReady), .byteNeeded(byteNeeded),
    .cmdDone(cmdDone), .forceIrq(forceIrq),
    .strb(strb), .busOe(hostDataOe), .drq(drq), .lostData(lostData),
    .busy(busy), .intrq(intrq), .cmdStart(cmdStart)
  );

  fdc_host_dpath #(.DATA_W(8)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .hostDataIn(hostDataIn), .diskByteIn(diskByteIn),
    .byteReady(byteReady), .byteNeeded(byteNeeded),
    .drq(drq), .lostData(lostData), .busy(busy),
    .hostDataOut(hostDataOut), .diskByteOut(diskByteOut), .cmdCode(cmdCode)
  );

  AST_PAD_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> !csN && rdWrN); // R1
endmodule

// File: tb/fdc_host_regs_bench.sv
`timescale 1ns/1ps
module fdc_host_regs_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdWrN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] hostDataIn = '0, diskByteIn = '0;
  logic byteReady = 1'b0, byteNeeded = 1'b0, cmdDone = 1'b0, forceIrq = 1'b0;
  logic [7:0] hostDataOut, diskByteOut, cmdCode;
  logic hostDataOe, cmdStart, drq, intrq;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic mDrq = 0, mLost = 0, mBusy = 0, mIntrq = 0, mCsHeld = 0, mStartPend = 0;
  logic [7:0] mData = 0, mTrack = 0, mSector = 0, mCmd = 0;

  always #4 clk = ~clk;

  fdc_host_regs u_fdc_host_regs (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addr(addr),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .byteReady(byteReady), .diskByteIn(diskByteIn), .byteNeeded(byteNeeded),
    .diskByteOut(diskByteOut), .cmdDone(cmdDone), .forceIrq(forceIrq),
    .cmdStart(cmdStart), .cmdCode(cmdCode), .drq(drq), .intrq(intrq)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, mLost, mDrq, mBusy};
      2'd1: return mTrack;
      2'd2: return mSector;
      default: return mData;
    endcase
  endfunction

  // one clock cycle: apply at negedge, check before posedge, advance model
  task automatic step(input bit cs, input bit rw, input logic [1:0] a, input logic [7:0] wd,
                      input bit br, input logic [7:0] bi, input bit bn,
                      input bit dn, input bit fi);
    bit st, wCmd, wTrk, wSec, wDat, rSta, rDat;
    csN = !cs; rdWrN = rw; addr = a; hostDataIn = wd;
    byteReady = br; diskByteIn = bi; byteNeeded = bn; cmdDone = dn; forceIrq = fi;
    #1;
    chk("R1 pad enable", int'(hostDataOe), int'(cs && rw));
    if (cs && rw)
      chk(a == 2'd0 ? "R4 status byte" : "R2 register read", int'(hostDataOut), int'(expRead(a)));
    chk("R5 drq pin", int'(drq), int'(mDrq));
    chk("R10 intrq pin", int'(intrq), int'(mIntrq));
    chk("R9 cmdStart pulse", int'(cmdStart), int'(mStartPend));
    if (mStartPend) chk("R9 cmdCode", int'(cmdCode), int'(mCmd));
    if (bn) chk(mDrq ? "R8 zero substitution" : "R7 outgoing byte",
                int'(diskByteOut), int'(mDrq ? 8'h00 : mData));
    st   = cs && !mCsHeld;
    wCmd = st && !rw && a == 2'd0;  wTrk = st && !rw && a == 2'd1;
    wSec = st && !rw && a == 2'd2;  wDat = st && !rw && a == 2'd3;
    rSta = st &&  rw && a == 2'd0;  rDat = st &&  rw && a == 2'd3;
    if (wCmd) mLost = 0; else if ((br || bn) && mDrq) mLost = 1;
    if (br) mDrq = 1; else if (bn) mDrq = !wDat; else if (wDat || rDat) mDrq = 0;
    if (br) mData = bi; else if (wDat) mData = wd;
    if (wCmd) mBusy = 1; else if (dn) mBusy = 0;
    if (wCmd) mIntrq = 0; else if (dn || fi) mIntrq = 1; else if (rSta) mIntrq = 0;
    if (wCmd) mCmd = wd;
    if (wTrk) mTrack = wd;
    if (wSec) mSector = wd;
    mStartPend = wCmd;
    mCsHeld = cs;
    @(negedge clk);
    csN = 1'b1; byteReady = 0; byteNeeded = 0; cmdDone = 0; forceIrq = 0;
  endtask

  task automatic idle(); step(0, 1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic hwr(input logic [1:0] a, input logic [7:0] d); step(1, 0, a, d, 0, 0, 0, 0, 0); idle(); endtask
  task automatic hrd(input logic [1:0] a); step(1, 1, a, 0, 0, 0, 0, 0, 0); idle(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 drq after reset", int'(drq), 0);
    chk("R12 intrq after reset", int'(intrq), 0);
    chk("R12 cmdCode after reset", int'(cmdCode), 0);
    hrd(0); hrd(1); hrd(2); hrd(3);

    // R2 register map with distinct values
    hwr(1, 8'h27); hwr(2, 8'h09); hrd(1); hrd(2);

    // R3 held select: only the first cycle's data counts
    step(1, 0, 1, 8'h5A, 0, 0, 0, 0, 0);
    step(1, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
    step(1, 0, 2, 8'hC3, 0, 0, 0, 0, 0);
    idle(); hrd(1); hrd(2);
    chk("R3 held select keeps track", int'(mTrack), 8'h5A);

    // R5 / R6 read flow with overrun
    step(0, 1, 0, 0, 1, 8'h11, 0, 0, 0); hrd(0); hrd(3);
    step(0, 1, 0, 0, 1, 8'h22, 0, 0, 0);
    step(0, 1, 0, 0, 1, 8'h33, 0, 0, 0); hrd(0); hrd(3);
    chk("R6 overrun flagged", int'(mLost), 1);

    // R9 command write clears lost, raises busy
    hwr(0, 8'h8C); hrd(0);
    // R7 / R8 write flow with underrun
    hwr(3, 8'h44);
    step(0, 1, 0, 0, 0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1, 0, 0); hrd(0);
    hwr(3, 8'h55); step(0, 1, 0, 0, 0, 0, 1, 0, 0);

    // R10 completion and force interrupt; R11 status read clears
    step(0, 1, 0, 0, 0, 0, 0, 1, 0); hrd(0); hrd(0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 1); hrd(0);
    // R11 status read in the same cycle as completion keeps intrq
    hwr(0, 8'h1F);
    step(1, 1, 0, 0, 0, 0, 0, 1, 0); idle();
    chk("R11 intrq survives read+done", int'(intrq), 1);
    // R10 command write overrides completion in the same cycle
    step(1, 0, 0, 8'hE4, 0, 0, 0, 1, 1); idle(); hrd(0);

    // R13 collisions between disk strobes and host data writes
    step(1, 0, 3, 8'h66, 1, 8'h77, 0, 0, 0); idle(); hrd(3);
    hwr(0, 8'h30);
    step(1, 0, 3, 8'h88, 0, 0, 1, 0, 0); idle();
    chk("R13 drq after write+needed", int'(drq), 0);
    step(0, 1, 0, 0, 0, 0, 1, 0, 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit cs, rw;
      r  = $urandom % 10;
      cs = (r < 5);
      rw = $urandom % 2;
      step(cs, rw, 2'($urandom % 4), 8'($urandom),
           r == 5, 8'($urandom), r == 6,
           (r == 7) || (r == 9 && ($urandom % 2) == 1), r == 8);
    end
    idle(); hrd(0); hrd(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule